// File: doc/BRIEF.md
# Pulse-Width-Keyed Tone Bus Transmitter

This block is the sending side of a single-master control link that signals over a coaxial feed by switching a 22 kHz carrier on and off. The caller hands it message bytes through a valid/ready handshake, with a flag on the final byte. The block adds an odd parity bit to every byte and shifts the nine bits out most significant first. Each bit takes three equal slots, and the bit value sets how many of those slots carry the carrier. The block also drives a gated square wave of its own, so it can feed an output stage directly.

After a message the block can send a short tone burst that picks one of two satellite positions. It can also hold a steady carrier while it is idle. Every phase is kept apart by silent gaps, and a message always ends with a silent tail. All durations are set by parameters: the system clock frequency, the slot length in microseconds and the carrier frequency. A bench can therefore run the block with a much shorter slot.

Top module: `pwk_tone_tx`

## Requirements
- R1: A data bit lasts 3 slots, each SLOT_US microseconds long. A 0 bit has the carrier on in slots 0 and 1 and off in slot 2. A 1 bit has it on in slot 0 and off in slots 1 and 2.
- R2: Each byte is sent as its bits 7 down to 0, followed by one parity bit equal to the XNOR of all eight bits, which makes the count of ones odd.
- R3: When a byte is waiting in the holding register as a bit period ends, the next byte starts in the very next slot, with no gap.
- R4: `in_ready` is high exactly when the single-entry holding register is empty. A byte is accepted on a clock edge where both `in_valid` and `in_ready` are high, including while the block is busy. After an accepted byte, `in_ready` is low on the next cycle.
- R5: A message ends after the byte that carried `in_last`. It also ends if no byte is waiting when a byte finishes; a byte that arrives later starts a new message.
- R6: After a message, or after a burst, the carrier is off for a tail of 12 slots. The tail is 32 slots instead if a burst was sent, or if `tone_en` is high when the tail begins. `busy` stays high until the tail has fully elapsed.
- R7: If `burst_en` was high when the last byte was accepted, the message is followed by 32 silent slots and then a 25-slot burst. When `burst_sel` is 0 the burst is steady carrier (position A). When it is 1 the carrier is on only in burst slots 0, 3, 6, …, 24, giving 9 pulses (position B).
- R8: While the block is idle, `tone_gate` follows `tone_en` one cycle later. While `busy` is high, the steady tone never reaches the output.
- R9: If the steady tone is on when a message is waiting, 32 silent slots come before the first bit.
- R10: `tone_out` is 0 whenever `tone_gate` is 0. While the gate is on, `tone_out` is a square wave with a period of 2·(CLK_FREQ_HZ/(2·TONE_HZ)) cycles.
- R11: After reset, `busy`, `tone_gate` and `tone_out` are 0 and `in_ready` is 1.
- R12: `busy` goes high on the first clock edge after the block leaves idle, and it stays high through every slot of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | The offered byte is the final byte of the message |
| burst_en | input | 1 | Send a tone burst after this message; sampled with the last byte |
| burst_sel | input | 1 | Burst kind: 0 = steady (A), 1 = pulsed (B); sampled with the last byte |
| in_ready | output | 1 | Holding register is empty |
| tone_en | input | 1 | Request a steady carrier while idle |
| tone_gate | output | 1 | Carrier envelope (1 = carrier on) |
| tone_out | output | 1 | Gated carrier square wave |
| busy | output | 1 | A sequence is in progress |

## Verification
On every cycle the checker confirms four things: the square wave is silent whenever the envelope is off, `in_ready` drops after each accepted byte, the idle envelope tracks the tone request, and `busy` never falls before at least a short tail of silence.

Some behaviour can only be seen by comparing whole slot sequences against envelopes that the bench builds from the rules above. This covers the bit shapes, the parity and bit order across a sweep of byte values, back-to-back bytes, the early end of a message when the next byte is late, the silence before a message when the tone is on, the two burst patterns, and the long tail.

// File: rtl/pwk_tx_pkg.sv
// Shared constants and types for the pulse-width-keyed tone transmitter.
// All phase lengths are counted in slots. A slot is the basic 0.5 ms unit,
// and its length in clock cycles is derived in the top module.
package pwk_tx_pkg;

    localparam int unsigned SLOTS_PER_BIT    = 3;
    localparam int unsigned BITS_PER_BYTE    = 9;   // eight data bits and parity
    localparam int unsigned TAIL_SHORT_SLOTS = 12;  // 6 ms of closing silence
    localparam int unsigned GAP_SLOTS        = 32;  // 16 ms, above the 15 ms gap
    localparam int unsigned BURST_SLOTS      = 25;  // 12.5 ms burst

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_GAP,
        ST_DATA,
        ST_MID_GAP,
        ST_BURST,
        ST_TAIL
    } seq_state_t;

    // Parity bit that makes the total count of ones odd.
    function automatic logic odd_parity(input logic [7:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/pwk_slot_timer.sv
// Slot timer: while run is high it divides the clock into slots of
// SLOT_CYC cycles and pulses tick in the last cycle of each slot.
// Assumes run is held low in idle, so the first slot after a start is full.
module pwk_slot_timer #(
    parameter int unsigned SLOT_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

    logic [CW-1:0] cnt;

    // Count cycles within the current slot, and clear the count when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(SLOT_CYC - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(SLOT_CYC - 1));

endmodule

// File: rtl/pwk_carrier_gen.sv
// Carrier generator: a free-running divider makes a square wave with a
// half period of HALF_CYC cycles, which is passed out only while gate is high.
// Assumes HALF_CYC is at least 1.
module pwk_carrier_gen #(
    parameter int unsigned HALF_CYC = 1136
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic carrier
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;
    logic          sq;

    // Toggle the square wave every HALF_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign carrier = gate & sq;

endmodule

// File: rtl/pwk_bit_shifter.sv
// Byte shifter: holds a byte with its parity bit and walks through the
// nine bits, MSB first, three slots per bit. It produces the envelope of
// the current slot. A load takes priority over an advance in the same cycle.
module pwk_bit_shifter
    import pwk_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       advance,
    output logic       env,
    output logic       at_end
);
    logic [BITS_PER_BYTE-1:0] sh;
    logic [3:0]               bit_idx;
    logic [1:0]               slot_idx;

    // Load a new byte, or step to the next slot and bit on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (load) begin
            sh       <= {load_byte, odd_parity(load_byte)};
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (advance) begin
            if (slot_idx == 2'(SLOTS_PER_BIT - 1)) begin
                slot_idx <= '0;
                bit_idx  <= bit_idx + 1'b1;
                sh       <= {sh[BITS_PER_BYTE-2:0], 1'b0};
            end else begin
                slot_idx <= slot_idx + 1'b1;
            end
        end
    end

    // Slot 0 always carries tone; slot 1 carries it only for a 0 bit.
    assign env    = (slot_idx == 2'd0) || ((slot_idx == 2'd1) && !sh[BITS_PER_BYTE-1]);
    assign at_end = (bit_idx == 4'(BITS_PER_BYTE - 1)) && (slot_idx == 2'(SLOTS_PER_BIT - 1));

endmodule

// File: rtl/pwk_tone_tx.sv
// Pulse-width-keyed tone bus transmitter (top).
// Takes bytes through a valid/ready handshake with a single-entry holding
// register, and runs this sequence: optional lead gap (when the steady tone
// was on), data, optional gap and tone burst, then a silent tail. It drives
// the carrier envelope and the gated carrier. Assumes the caller offers each
// next byte before the current byte ends; a late byte ends the message.
module pwk_tone_tx
    import pwk_tx_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned SLOT_US     = 500,
    parameter int unsigned TONE_HZ     = 22_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       burst_en,
    input  logic       burst_sel,
    output logic       in_ready,
    input  logic       tone_en,
    output logic       tone_gate,
    output logic       tone_out,
    output logic       busy
);
    localparam int unsigned SLOT_CYC = (CLK_FREQ_HZ / 1_000_000) * SLOT_US;
    localparam int unsigned HALF_CYC = CLK_FREQ_HZ / (2 * TONE_HZ);
    localparam int unsigned PHW      = $clog2(GAP_SLOTS);
    localparam logic [PHW-1:0] GAP_END   = PHW'(GAP_SLOTS - 1);
    localparam logic [PHW-1:0] BURST_END = PHW'(BURST_SLOTS - 1);
    localparam logic [PHW-1:0] SHORT_END = PHW'(TAIL_SHORT_SLOTS - 1);

    seq_state_t     st, st_nx;
    logic           tick;
    logic           take;
    logic [PHW-1:0] ph_cnt;
    logic [PHW-1:0] tail_end;
    logic           tail_long;
    logic           tone_on;
    logic           env;
    logic           at_end;

    logic           hold_vld;
    logic [7:0]     hold_byte;
    logic           hold_last;
    logic           hold_bst_en;
    logic           hold_bst_sel;
    logic           cur_last;
    logic           act_bst_en;
    logic           act_bst_sel;
    logic           accept;

    assign in_ready = !hold_vld;
    assign accept   = in_valid && !hold_vld;
    assign busy     = (st != ST_IDLE);
    assign tail_end = tail_long ? GAP_END : SHORT_END;

    pwk_slot_timer #(.SLOT_CYC(SLOT_CYC)) slot_timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    pwk_bit_shifter shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_byte (hold_byte),
        .advance   (tick),
        .env       (env),
        .at_end    (at_end)
    );

    pwk_carrier_gen #(.HALF_CYC(HALF_CYC)) carrier_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (tone_gate),
        .carrier (tone_out)
    );

    // Holding register: capture an offered byte when empty, release it on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld     <= 1'b0;
            hold_byte    <= '0;
            hold_last    <= 1'b0;
            hold_bst_en  <= 1'b0;
            hold_bst_sel <= 1'b0;
        end else if (accept) begin
            hold_vld     <= 1'b1;
            hold_byte    <= in_data;
            hold_last    <= in_last;
            hold_bst_en  <= in_last && burst_en;
            hold_bst_sel <= burst_sel;
        end else if (take) begin
            hold_vld     <= 1'b0;
        end
    end

    // Attributes of the byte now in the shifter, copied when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_last    <= 1'b0;
            act_bst_en  <= 1'b0;
            act_bst_sel <= 1'b0;
        end else if (take) begin
            cur_last    <= hold_last;
            act_bst_en  <= hold_bst_en;
            act_bst_sel <= hold_bst_sel;
        end
    end

    // Sequencer next state and the byte-take strobe.
    always_comb begin
        st_nx = st;
        take  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (hold_vld) begin
                    if (tone_on) begin
                        st_nx = ST_LEAD_GAP;
                    end else begin
                        st_nx = ST_DATA;
                        take  = 1'b1;
                    end
                end
            end
            ST_LEAD_GAP: begin
                if (tick && ph_cnt == GAP_END) begin
                    st_nx = ST_DATA;
                    take  = 1'b1;
                end
            end
            ST_DATA: begin
                if (tick && at_end) begin
                    if (!cur_last && hold_vld) begin
                        take = 1'b1;
                    end else if (act_bst_en) begin
                        st_nx = ST_MID_GAP;
                    end else begin
                        st_nx = ST_TAIL;
                    end
                end
            end
            ST_MID_GAP: begin
                if (tick && ph_cnt == GAP_END) begin
                    st_nx = ST_BURST;
                end
            end
            ST_BURST: begin
                if (tick && ph_cnt == BURST_END) begin
                    st_nx = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (tick && ph_cnt == tail_end) begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Slot count within the current phase, cleared on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || (st_nx != st)) begin
            ph_cnt <= '0;
        end else if (tick) begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // Pick the tail length as the tail begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_long <= 1'b0;
        end else if (st_nx == ST_TAIL && st != ST_TAIL) begin
            tail_long <= (st == ST_BURST) || tone_en;
        end
    end

    // Steady tone: allowed only while idle with nothing waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_on <= 1'b0;
        end else begin
            tone_on <= (st == ST_IDLE) && (st_nx == ST_IDLE) && tone_en;
        end
    end

    // Carrier envelope for the current phase.
    always_comb begin
        unique case (st)
            ST_IDLE:  tone_gate = tone_on;
            ST_DATA:  tone_gate = env;
            ST_BURST: tone_gate = act_bst_sel ? ((ph_cnt % PHW'(3)) == '0) : 1'b1;
            default:  tone_gate = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwk_tone_tx_chk.sv
// Checker for pwk_tone_tx, bound to every instance. It watches only the
// ports, and counts silent busy cycles to judge the length of the tail.
module pwk_tone_tx_chk #(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned SLOT_US     = 500
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tone_en,
    input logic tone_gate,
    input logic tone_out,
    input logic busy
);
    localparam int unsigned SLOT_CYC = (CLK_FREQ_HZ / 1_000_000) * SLOT_US;
    localparam int unsigned TAIL_MIN = 12 * SLOT_CYC;

    logic [31:0] sil_cnt;
    logic        warm;

    // Track whether the previous cycle was out of reset.
    always_ff @(posedge clk) warm <= rst_n;

    // Count consecutive busy cycles with the carrier off.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || tone_gate) begin
            sil_cnt <= (rst_n && busy && !tone_gate) ? 32'd1 : 32'd0;
        end else if (sil_cnt != 32'hFFFF_FFFF) begin
            sil_cnt <= sil_cnt + 1'b1;
        end
    end

    AST_GATED_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_gate |-> !tone_out); // R10

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready); // R4

    AST_IDLE_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !busy && $past(!busy) |-> tone_gate == $past(tone_en)); // R8

    AST_TAIL_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $fell(busy) |-> sil_cnt >= TAIL_MIN); // R6

endmodule

bind pwk_tone_tx pwk_tone_tx_chk #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .SLOT_US     (SLOT_US)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tone_en   (tone_en),
    .tone_gate (tone_gate),
    .tone_out  (tone_out),
    .busy      (busy)
);

// File: tb/pwk_tone_tx_tb_top.sv
// Bench for pwk_tone_tx, scaled to 8-cycle slots and a 4-cycle carrier half
// period. Expected envelopes are built slot by slot from the requirements.
module pwk_tone_tx_tb_top;

    localparam int SLOT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       burst_en = 1'b0;
    logic       burst_sel = 1'b0;
    logic       in_ready;
    logic       tone_en = 1'b0;
    logic       tone_gate;
    logic       tone_out;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_env [0:511];
    int exp_n = 0;

    always #10 clk = ~clk;

    pwk_tone_tx #(
        .CLK_FREQ_HZ (8_000_000),
        .SLOT_US     (1),
        .TONE_HZ     (1_000_000)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .burst_en  (burst_en),
        .burst_sel (burst_sel),
        .in_ready  (in_ready),
        .tone_en   (tone_en),
        .tone_gate (tone_gate),
        .tone_out  (tone_out),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic add_slots(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            exp_env[exp_n] = v;
            exp_n++;
        end
    endtask

    // R1 bit shapes: 0 -> on,on,off ; 1 -> on,off,off
    task automatic add_bit(input logic b);
        add_slots(1'b1, 1);
        add_slots(!b, 1);
        add_slots(1'b0, 1);
    endtask

    // R2: MSB first, then the parity bit that makes the ones count odd
    task automatic add_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) add_bit(b[i]);
        add_bit(~^b);
    endtask

    task automatic add_burst_b();
        for (int k = 0; k < 25; k++) add_slots((k % 3) == 0, 1);
    endtask

    task automatic push(input logic [7:0] d, input logic last, input logic ben, input logic bsel);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_last   = last;
        burst_en  = ben;
        burst_sel = bsel;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        burst_en = 1'b0;
    endtask

    // Compare one whole sequence against exp_env, one sample mid-slot.
    task automatic watch(input string tag);
        @(posedge busy);
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < exp_n; k++) begin
            chk(tag, {31'd0, tone_gate}, {31'd0, exp_env[k]});
            chk("R12 busy held", {31'd0, busy}, 32'd1);
            if (!exp_env[k]) chk("R10 no carrier when gated off", {31'd0, tone_out}, 32'd0);
            repeat (SLOT) @(negedge clk);
        end
        chk("R6 busy low after tail", {31'd0, busy}, 32'd0);
        chk("R8 idle envelope follows tone", {31'd0, tone_gate}, {31'd0, tone_en});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 gate", {31'd0, tone_gate}, 32'd0);
        chk("R11 ready", {31'd0, in_ready}, 32'd1);
        chk("R11 carrier", {31'd0, tone_out}, 32'd0);

        // R1/R3: three bytes back to back, short tail
        exp_n = 0;
        add_byte(8'hE0); add_byte(8'h10); add_byte(8'h38); add_slots(1'b0, 12);
        fork
            watch("R1/R3 three-byte envelope");
            begin
                push(8'hE0, 1'b0, 1'b0, 1'b0);
                push(8'h10, 1'b0, 1'b0, 1'b0);
                chk("R4 holding full while busy", {31'd0, in_ready}, 32'd0);
                push(8'h38, 1'b1, 1'b0, 1'b0);
            end
        join
        repeat (3) @(negedge clk);

        // R7: burst A (steady) after a two-byte message
        exp_n = 0;
        add_byte(8'hA5); add_byte(8'h00);
        add_slots(1'b0, 32); add_slots(1'b1, 25); add_slots(1'b0, 32);
        fork
            watch("R7 burst A envelope");
            begin
                push(8'hA5, 1'b0, 1'b0, 1'b0);
                push(8'h00, 1'b1, 1'b1, 1'b0);
            end
        join
        repeat (3) @(negedge clk);

        // R8/R10: steady tone while idle
        tone_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 tone while idle", {31'd0, tone_gate}, 32'd1);
        begin
            int rises = 0;
            logic prev = tone_out;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (tone_out && !prev) rises++;
                prev = tone_out;
            end
            chk("R10 carrier period", rises, 32'd2);
        end

        // R9/R7: lead gap when tone was on, then burst B
        exp_n = 0;
        add_slots(1'b0, 32); add_byte(8'hFF);
        add_slots(1'b0, 32); add_burst_b(); add_slots(1'b0, 32);
        fork
            watch("R9/R7 lead gap and burst B envelope");
            push(8'hFF, 1'b1, 1'b1, 1'b1);
        join
        tone_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 tone released", {31'd0, tone_gate}, 32'd0);

        // R5: missing next byte ends the message; late byte is a new one
        exp_n = 0;
        add_byte(8'h3C); add_slots(1'b0, 12);
        fork
            watch("R5 early end envelope");
            push(8'h3C, 1'b0, 1'b0, 1'b0);
        join
        exp_n = 0;
        add_byte(8'h81); add_slots(1'b0, 12);
        fork
            watch("R5 late byte as new message");
            push(8'h81, 1'b1, 1'b0, 1'b0);
        join

        // R2 sweep of single-byte messages over spread values
        for (int v = 0; v < 256; v += 17) begin
            exp_n = 0;
            add_byte(8'(v)); add_slots(1'b0, 12);
            fork
                watch("R2 sweep envelope");
                push(8'(v), 1'b1, 1'b0, 1'b0);
            join
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule